// File: doc/BRIEF.md
# IN Endpoint Transmit Packet FIFO

This block is the transmit-side packet buffer of one USB IN endpoint. A processor loads packet bytes one at a time and then commits them as a complete packet. A serial engine on the other side reads the oldest packet byte by byte. When that packet has gone out on the bus, the engine signals completion and the packet's slot is released. Each slot keeps its own byte count, so the engine always knows how many bytes to send, and zero-length packets are allowed.

The byte store is split into two packet slots when twice the maximum packet size fits in the store (double-buffer mode). Otherwise the whole store forms one slot (single-buffer mode). The occupancy is reported as two bits: a ready bit and a not-empty bit. What the two bits mean depends on the mode. A flush pulse discards the oldest stored packet. A commit attempt while every slot is occupied is dropped and latches an error flag.

Top module: `inep_tx_fifo`

## Requirements
- R1: Double-buffer mode is used when 2*MAXP <= DEPTH. In that mode, occupancy is encoded as {pkt_rdy,not_empty}: 0 packets = 00, 1 packet = 01, 2 packets = 11. The value 10 never appears.
- R2: Single-buffer mode is used when 2*MAXP > DEPTH. In that mode, 0 packets = 00 and 1 packet = 11. The values 01 and 10 never appear.
- R3: A tx_done pulse while packets are held removes the oldest packet. In double-buffer mode with two packets held, this clears pkt_rdy on the next cycle while not_empty stays 1.
- R4: A flush pulse removes only the oldest stored packet. The newer packet stays intact. A flush while empty has no effect.
- R5: A wr_commit while all slots are full is ignored and sets load_err. load_err stays 1 until reset. Bytes offered on wr_valid while all slots are full are dropped.
- R6: tx_len gives the byte count of the oldest stored packet and is 0 when the FIFO is empty. tx_data presents that packet's bytes in write order, and each tx_pop advances to the next byte.
- R7: Bytes written beyond MAXP into one packet are dropped, so the stored length never exceeds MAXP. A commit with no bytes stores a zero-length packet.
- R8: If flush and tx_done arrive in the same cycle, exactly one packet (the oldest) is removed.
- R9: After reset, the FIFO is empty: pkt_rdy, not_empty and load_err are 0, and tx_len is 0.
- R10: A byte presented on wr_valid in the same cycle as wr_commit belongs to the packet being committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write one byte into the packet being loaded |
| wr_data | input | DW | Byte to load |
| wr_commit | input | 1 | Close the packet being loaded and queue it |
| flush | input | 1 | Discard the oldest stored packet |
| tx_pop | input | 1 | Advance to the next byte of the oldest packet |
| tx_done | input | 1 | Transmission of the oldest packet completed |
| pkt_rdy | output | 1 | Ready status bit |
| not_empty | output | 1 | Not-empty status bit |
| load_err | output | 1 | Sticky flag: a commit was attempted while full |
| tx_len | output | LW | Byte count of the oldest packet |
| tx_data | output | DW | Current byte of the oldest packet |

## Verification
The bench builds two copies of the block with a 16-byte store and drives them with the same stimulus. One copy has an 8-byte maximum packet size, which selects double-buffer mode. The other has a 12-byte maximum packet size, which selects single-buffer mode. Because the stores are small, both copies reach full occupancy, the ready drop with a second packet queued, and flush of the older of two packets within a few events. Identical stimulus also makes the overflow behaviour of the two modes diverge: the same second load is accepted by one copy and refused with an error by the other. An 11-byte load reaches the packet-size limit in the double-buffer copy only.

// File: rtl/inep_pkg.sv
package inep_pkg;

    // Two packet slots fit when twice the max packet size fits in the store.
    function automatic bit use_double(input int depth, input int maxp);
        return (2 * maxp) <= depth;
    endfunction

endpackage

// File: rtl/inep_pkt_ram.sv
module inep_pkt_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/inep_occ_status.sv
module inep_occ_status #(
    parameter bit DBL = 1'b1
) (
    input  logic [1:0] cnt,
    output logic       rdy,
    output logic       ne
);

    generate
        if (DBL) begin : g_double
            // 0 -> 00, 1 -> 01, 2 -> 11
            assign rdy = (cnt == 2'd2);
            assign ne  = (cnt != 2'd0);
        end else begin : g_single
            // 0 -> 00, 1 -> 11
            assign rdy = (cnt == 2'd1);
            assign ne  = (cnt == 2'd1);
        end
    endgenerate

endmodule

// File: rtl/inep_ctrl.sv
module inep_ctrl #(
    parameter int DEPTH = 64,
    parameter int MAXP  = 32,
    parameter bit DBL   = 1'b1,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_commit,
    input  logic          flush,
    input  logic          tx_pop,
    input  logic          tx_done,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic [1:0]    cnt,
    output logic [LW-1:0] tx_len,
    output logic          load_err
);

    localparam logic [1:0]    CAP      = DBL ? 2'd2 : 2'd1;
    localparam int            SLOT_OFS = DBL ? DEPTH / 2 : 0;
    localparam logic [LW-1:0] MAXP_L   = LW'(MAXP);

    typedef struct packed {
        logic [1:0]         cnt;
        logic               head;
        logic               tail;
        logic [LW-1:0]      wr_off;
        logic [LW-1:0]      rd_off;
        logic [1:0][LW-1:0] len;
        logic               err;
    } state_t;

    state_t s_d, s_q;

    logic          full, have, we, take, drop;
    logic [LW-1:0] wlen;

    always_comb begin
        s_d  = s_q;
        full = (s_q.cnt == CAP);
        have = (s_q.cnt != 2'd0);
        we   = wr_valid && !full && (s_q.wr_off < MAXP_L);
        wlen = s_q.wr_off + LW'(we);
        take = wr_commit && !full;
        drop = (flush || tx_done) && have;

        if (we) begin
            s_d.wr_off = s_q.wr_off + 1'b1;
        end
        if (wr_commit && full) begin
            s_d.err = 1'b1;
        end
        if (take) begin
            s_d.len[s_q.tail] = wlen;
            s_d.wr_off        = '0;
            if (DBL) begin
                s_d.tail = ~s_q.tail;
            end
        end

        if (drop) begin
            s_d.rd_off = '0;
            if (DBL) begin
                s_d.head = ~s_q.head;
            end
        end else if (tx_pop && have && (s_q.rd_off < s_q.len[s_q.head])) begin
            s_d.rd_off = s_q.rd_off + 1'b1;
        end

        case ({take, drop})
            2'b10:   s_d.cnt = s_q.cnt + 2'd1;
            2'b01:   s_d.cnt = s_q.cnt - 2'd1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we    = we;
    assign mem_waddr = (s_q.tail ? AW'(SLOT_OFS) : AW'(0)) + AW'(s_q.wr_off);
    assign mem_raddr = (s_q.head ? AW'(SLOT_OFS) : AW'(0)) + AW'(s_q.rd_off);
    assign cnt       = s_q.cnt;
    assign tx_len    = have ? s_q.len[s_q.head] : '0;
    assign load_err  = s_q.err;

endmodule

// File: rtl/inep_tx_fifo.sv
module inep_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int MAXP  = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_commit,
    input  logic          flush,
    input  logic          tx_pop,
    input  logic          tx_done,
    output logic          pkt_rdy,
    output logic          not_empty,
    output logic          load_err,
    output logic [LW-1:0] tx_len,
    output logic [DW-1:0] tx_data
);

    localparam bit DBL = inep_pkg::use_double(DEPTH, MAXP);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [1:0]    occ;

    inep_ctrl #(
        .DEPTH(DEPTH), .MAXP(MAXP), .DBL(DBL), .AW(AW), .LW(LW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_commit(wr_commit),
        .flush    (flush),
        .tx_pop   (tx_pop),
        .tx_done  (tx_done),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_raddr(mem_raddr),
        .cnt      (occ),
        .tx_len   (tx_len),
        .load_err (load_err)
    );

    inep_pkt_ram #(
        .DW(DW), .DEPTH(DEPTH), .AW(AW)
    ) u_ram (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .raddr(mem_raddr),
        .rdata(tx_data)
    );

    inep_occ_status #(
        .DBL(DBL)
    ) u_status (
        .cnt(occ),
        .rdy(pkt_rdy),
        .ne (not_empty)
    );

endmodule

// File: rtl/inep_tx_fifo_chk.sv
module inep_tx_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int MAXP  = 32,
    parameter int LW    = $clog2(MAXP + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_commit,
    input logic          flush,
    input logic          tx_done,
    input logic          pkt_rdy,
    input logic          not_empty,
    input logic          load_err,
    input logic [LW-1:0] tx_len
);

    localparam bit DBL = inep_pkg::use_double(DEPTH, MAXP);

    assert_no_ready_without_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rdy |-> not_empty);

    generate
        if (DBL) begin : g_dbl
            assert_ready_drops_queued_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_done && pkt_rdy && !wr_commit && !flush) |=> (!pkt_rdy && not_empty));
        end else begin : g_sgl
            assert_single_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
                pkt_rdy == not_empty);
            assert_single_done_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_done && pkt_rdy && !wr_commit) |=> !not_empty);
        end
    endgenerate

    assert_flush_empty_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !not_empty && !wr_commit) |=> !not_empty);

    assert_full_commit_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && pkt_rdy) |=> load_err);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    assert_empty_len_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> (tx_len == '0));

    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_len <= LW'(MAXP));

endmodule

bind inep_tx_fifo inep_tx_fifo_chk #(
    .DEPTH(DEPTH), .MAXP(MAXP), .LW(LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_commit(wr_commit),
    .flush    (flush),
    .tx_done  (tx_done),
    .pkt_rdy  (pkt_rdy),
    .not_empty(not_empty),
    .load_err (load_err),
    .tx_len   (tx_len)
);

// File: tb/inep_tx_fifo_test.sv
module inep_tx_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int MAXP_D     = 8;
    localparam int MAXP_S     = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_commit = 1'b0;
    logic       flush = 1'b0;
    logic       tx_pop = 1'b0;
    logic       tx_done = 1'b0;

    logic       d_rdy, d_ne, d_err, s_rdy, s_ne, s_err;
    logic [3:0] d_len, s_len;
    logic [7:0] d_data, s_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inep_tx_fifo #(.DW(8), .DEPTH(DEPTH), .MAXP(MAXP_D)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_commit(wr_commit), .flush(flush), .tx_pop(tx_pop), .tx_done(tx_done),
        .pkt_rdy(d_rdy), .not_empty(d_ne), .load_err(d_err),
        .tx_len(d_len), .tx_data(d_data)
    );

    inep_tx_fifo #(.DW(8), .DEPTH(DEPTH), .MAXP(MAXP_S)) uut_single (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_commit(wr_commit), .flush(flush), .tx_pop(tx_pop), .tx_done(tx_done),
        .pkt_rdy(s_rdy), .not_empty(s_ne), .load_err(s_err),
        .tx_len(s_len), .tx_data(s_data)
    );

    // op: 0 load n bytes from base, 1 send n bytes (data checked on the
    // double-buffer copy), 2 flush. Expected triples are {pkt_rdy,not_empty,load_err}.
    typedef struct packed {
        logic [1:0] op;
        logic [3:0] n;
        logic [7:0] base;
        logic [2:0] exp_d;
        logic [2:0] exp_s;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd3, 8'h10, 3'b010, 3'b110},
        '{2'd0, 4'd5, 8'h20, 3'b110, 3'b111},
        '{2'd1, 4'd3, 8'h10, 3'b010, 3'b001},
        '{2'd0, 4'd8, 8'h30, 3'b110, 3'b111},
        '{2'd2, 4'd0, 8'h00, 3'b010, 3'b001},
        '{2'd1, 4'd8, 8'h30, 3'b000, 3'b001},
        '{2'd0, 4'd0, 8'h00, 3'b010, 3'b111},
        '{2'd0, 4'd8, 8'h40, 3'b110, 3'b111},
        '{2'd0, 4'd2, 8'h50, 3'b111, 3'b111},
        '{2'd1, 4'd0, 8'h00, 3'b011, 3'b001},
        '{2'd1, 4'd8, 8'h40, 3'b001, 3'b001},
        '{2'd2, 4'd0, 8'h00, 3'b001, 3'b001}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_pkt(input int n, input int base);
        if (n == 0) begin
            @(negedge clk);
            wr_commit = 1'b1;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid  = 1'b1;
            wr_data   = 8'(base + i);
            wr_commit = (i == n - 1); // R10: last byte rides with the commit
        end
        @(negedge clk);
        wr_valid  = 1'b0;
        wr_commit = 1'b0;
    endtask

    task automatic send_pkt(input int n, input int base, input bit chk_data);
        @(negedge clk);
        if (chk_data) chk("R6 tx_len", int'(d_len), n);
        for (int i = 0; i < n; i++) begin
            if (chk_data) chk("R6 tx_data", int'(d_data), (base + i) & 8'hFF);
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic flush_one();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic chk_status(input string tag, input logic [2:0] ed, input logic [2:0] es);
        chk({tag, " R1 dbl pkt_rdy"},   int'(d_rdy), int'(ed[2]));
        chk({tag, " R1 dbl not_empty"}, int'(d_ne),  int'(ed[1]));
        chk({tag, " R5 dbl load_err"},  int'(d_err), int'(ed[0]));
        chk({tag, " R2 sgl pkt_rdy"},   int'(s_rdy), int'(es[2]));
        chk({tag, " R2 sgl not_empty"}, int'(s_ne),  int'(es[1]));
        chk({tag, " R5 sgl load_err"},  int'(s_err), int'(es[0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk_status("R9 reset", 3'b000, 3'b000);
        chk("R9 dbl tx_len", int'(d_len), 0);
        chk("R9 sgl tx_len", int'(s_len), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R10 across both modes
        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                2'd0:    load_pkt(int'(VEC[v].n), int'(VEC[v].base));
                2'd1:    send_pkt(int'(VEC[v].n), int'(VEC[v].base), 1'b1);
                default: flush_one();
            endcase
            chk_status($sformatf("vec%0d", v), VEC[v].exp_d, VEC[v].exp_s);
        end

        // R9: reset clears the sticky error
        do_reset();
        chk_status("R9 re-reset", 3'b000, 3'b000);

        // R7: an 11-byte load is truncated at MAXP in the double-buffer copy only
        load_pkt(11, 8'h60);
        chk("R7 dbl len capped", int'(d_len), MAXP_D);
        chk("R6 sgl len", int'(s_len), 11);
        chk("R6 sgl first byte", int'(s_data), 8'h60);
        send_pkt(MAXP_D, 8'h60, 1'b1);
        chk_status("R7 after send", 3'b000, 3'b000);

        // R8 and R4: flush with tx_done removes one packet, the oldest one
        load_pkt(2, 8'h70);
        load_pkt(3, 8'h80);
        chk_status("R8 two loaded", 3'b110, 3'b111);
        @(negedge clk);
        flush   = 1'b1;
        tx_done = 1'b1;
        @(negedge clk);
        flush   = 1'b0;
        tx_done = 1'b0;
        chk_status("R8 one removed", 3'b010, 3'b001);
        send_pkt(3, 8'h80, 1'b1); // R4: the newer packet is intact
        chk_status("R4 drained", 3'b000, 3'b001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule